// File: doc/BRIEF.md
# Receive Descriptor Ring DMA Writer

This block moves received frames from a byte stream into memory buffers that software lends it through a ring of descriptors. Each descriptor occupies 16 bytes in memory: a buffer pointer in the first word, a status/length word (info1) in the second, and two further words that the engine never touches. Software programs the ring location, its slot count and a CPU index through a small register file, then enables reception. For every frame the engine fetches the buffer pointer of the current slot. It packs the incoming bytes into 32-bit little-endian words and stores them, then writes the descriptor's info1 word with the byte count and a done flag. Finally it steps its DMA index around the ring and flags a receive-done event.

Ownership returns to the engine when software rewrites info1 and moves the CPU index onto the slot it just consumed. The engine stops one slot short of the CPU index. A frame that arrives while no slot is free is consumed and discarded, and an error flag is raised. Interrupt flags are cleared by writing ones, and a mask selects which of them drive the single interrupt line.

Top module: `rxring_dma`

## Requirements
- R1: After reset every register reads zero, and `irq`, `s_ready` and `mem_req` are low.
- R2: Frame bytes are stored little-endian from the word-aligned buffer pointer (first word of the slot's descriptor at ring base + 16 × DMA index). Byte i goes to lane i mod 4 of word i/4, and only written lanes have `mem_be` set.
- R3: After the last payload write the engine writes info1 (descriptor address + 4) as bit 31 done = 1, bit 30 last = 1, bits [29:16] = stored byte count, other bits 0. This is the final memory write of the frame.
- R4: Completing a frame advances the DMA index (register offset 3) by one, wrapping from count−1 to 0.
- R5: When the DMA index equals the CPU index (register offset 2), or the count is zero, an arriving frame is accepted and discarded. No memory access is made, the DMA index is unchanged, and status bit 31 is set.
- R6: Bytes beyond BUF_BYTES are accepted but not written, and the length field saturates at BUF_BYTES.
- R7: Completion sets status bit 16 (register offset 6). Writing 1 clears a status bit and writing 0 leaves it. `irq` is the OR of status AND mask (register offset 7).
- R8: Writing the index-reset register (offset 4) with bit 16 set forces the DMA index to 0.
- R9: Config register (offset 5) bit 2 enables reception; while it is clear and the engine is idle, `s_ready` stays low. Bit 3 reads 1 while a frame is in progress.
- R10: Once `mem_req` is raised it stays high with address, data, enables and direction unchanged until `mem_gnt`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational from `reg_addr`) |
| s_valid | input | 1 | Stream byte valid |
| s_data | input | 8 | Stream byte |
| s_last | input | 1 | Final byte of the frame |
| s_ready | output | 1 | Stream byte accepted when high with `s_valid` |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Memory request is a write |
| mem_addr | output | 32 | Memory byte address (word aligned) |
| mem_be | output | 4 | Write byte enables |
| mem_wdata | output | 32 | Write data |
| mem_gnt | input | 1 | Request accepted this cycle |
| mem_rdata | input | 32 | Read data, valid in the grant cycle |
| irq | output | 1 | Interrupt request |

## Verification
The bench sends frames of odd lengths, exact-buffer lengths and over-long lengths through a memory that withholds grants every few cycles. A packer that lost track of lanes would leave shifted bytes or stray enables in the buffer. A wrong truncation would overwrite the sentinel words beyond the buffer or report the raw count. Six frames on a four-slot ring catch an index that fails to wrap. A ring held full by the CPU index must leave memory and index untouched while still draining the stream; an engine that ignored the CPU index would overwrite a slot software still owns. Partial status writes, masked error flags, the mid-frame busy bit and the index reset are each read back through the register port.

// File: rtl/rxdma_pkg.sv
package rxdma_pkg;

  // Register word offsets (software visible)
  localparam logic [2:0] RA_BASE = 3'd0;
  localparam logic [2:0] RA_CNT  = 3'd1;
  localparam logic [2:0] RA_CPU  = 3'd2;
  localparam logic [2:0] RA_DMA  = 3'd3;
  localparam logic [2:0] RA_IRST = 3'd4;
  localparam logic [2:0] RA_GCFG = 3'd5;
  localparam logic [2:0] RA_STAT = 3'd6;
  localparam logic [2:0] RA_MASK = 3'd7;

  // Bit positions decoded by software
  localparam int GC_EN    = 2;
  localparam int GC_BUSY  = 3;
  localparam int IRST_BIT = 16;
  localparam int ST_DONE0 = 16;
  localparam int ST_DONE1 = 17;
  localparam int ST_ERR   = 31;

  // info1 layout
  localparam int LEN_W = 14;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_RPTR  = 3'd1,
    ST_FILL  = 3'd2,
    ST_WDATA = 3'd3,
    ST_WDESC = 3'd4,
    ST_DROP  = 3'd5
  } eng_st_t;

endpackage

// File: rtl/rxdma_pack.sv
module rxdma_pack (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       push,
  input  logic [1:0] lane,
  input  logic [7:0] din,
  input  logic       clr,
  output logic [31:0] word,
  output logic [3:0]  be
);

  logic [31:0] word_q, word_d;
  logic [3:0]  be_q, be_d;

  always_comb begin
    word_d = word_q;
    be_d   = be_q;
    if (clr) begin
      be_d = 4'h0;
    end else if (push) begin
      word_d[lane*8 +: 8] = din;
      be_d[lane]          = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= 32'h0;
      be_q   <= 4'h0;
    end else if (clr || push) begin
      word_q <= word_d;
      be_q   <= be_d;
    end
  end

  assign word = word_q;
  assign be   = be_q;

endmodule

// File: rtl/rxdma_regs.sv
module rxdma_regs
  import rxdma_pkg::*;
#(
  parameter int IDX_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic [2:0]       reg_addr,
  input  logic [31:0]      reg_wdata,
  output logic [31:0]      reg_rdata,
  input  logic [IDX_W-1:0] dma_idx,
  input  logic             busy,
  input  logic             done_evt,
  input  logic             err_evt,
  output logic [31:0]      ring_base,
  output logic [IDX_W:0]   ring_cnt,
  output logic [IDX_W-1:0] cpu_idx,
  output logic             rx_en,
  output logic             idx_rst,
  output logic             st_done,
  output logic             st_err,
  output logic             irq
);

  logic [31:0]      base_q, base_d;
  logic [IDX_W:0]   cnt_q, cnt_d;
  logic [IDX_W-1:0] cpu_q, cpu_d;
  logic             en_q, en_d;
  logic [2:0]       stat_q, stat_d;   // {err, done1, done0}
  logic [31:0]      mask_q, mask_d;
  logic [31:0]      stat_word;
  logic             wr_base, wr_cnt, wr_cpu, wr_gcfg, wr_stat, wr_mask;
  logic [2:0]       w1c;
  logic             unused_wbits;

  assign wr_base = reg_wr && (reg_addr == RA_BASE);
  assign wr_cnt  = reg_wr && (reg_addr == RA_CNT);
  assign wr_cpu  = reg_wr && (reg_addr == RA_CPU);
  assign wr_gcfg = reg_wr && (reg_addr == RA_GCFG);
  assign wr_stat = reg_wr && (reg_addr == RA_STAT);
  assign wr_mask = reg_wr && (reg_addr == RA_MASK);
  assign idx_rst = reg_wr && (reg_addr == RA_IRST) && reg_wdata[IRST_BIT];

  assign w1c = wr_stat ? {reg_wdata[ST_ERR], reg_wdata[ST_DONE1], reg_wdata[ST_DONE0]} : 3'b000;

  always_comb begin
    base_d = wr_base ? reg_wdata : base_q;
    cnt_d  = wr_cnt  ? reg_wdata[IDX_W:0] : cnt_q;
    cpu_d  = wr_cpu  ? reg_wdata[IDX_W-1:0] : cpu_q;
    en_d   = wr_gcfg ? reg_wdata[GC_EN] : en_q;
    mask_d = wr_mask ? reg_wdata : mask_q;
    // a new event wins over a clear in the same cycle
    stat_d = (stat_q & ~w1c) | {err_evt, 1'b0, done_evt};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= 32'h0;
      cnt_q  <= '0;
      cpu_q  <= '0;
      en_q   <= 1'b0;
      mask_q <= 32'h0;
      stat_q <= 3'b000;
    end else begin
      if (wr_base) base_q <= base_d;
      if (wr_cnt)  cnt_q  <= cnt_d;
      if (wr_cpu)  cpu_q  <= cpu_d;
      if (wr_gcfg) en_q   <= en_d;
      if (wr_mask) mask_q <= mask_d;
      if (wr_stat || done_evt || err_evt) stat_q <= stat_d;
    end
  end

  always_comb begin
    stat_word = 32'h0;
    stat_word[ST_DONE0] = stat_q[0];
    stat_word[ST_DONE1] = stat_q[1];
    stat_word[ST_ERR]   = stat_q[2];
  end

  always_comb begin
    reg_rdata = 32'h0;
    case (reg_addr)
      RA_BASE: reg_rdata = base_q;
      RA_CNT:  reg_rdata = {{(31-IDX_W){1'b0}}, cnt_q};
      RA_CPU:  reg_rdata = {{(32-IDX_W){1'b0}}, cpu_q};
      RA_DMA:  reg_rdata = {{(32-IDX_W){1'b0}}, dma_idx};
      RA_GCFG: begin
        reg_rdata[GC_EN]   = en_q;
        reg_rdata[GC_BUSY] = busy;
      end
      RA_STAT: reg_rdata = stat_word;
      RA_MASK: reg_rdata = mask_q;
      default: reg_rdata = 32'h0;
    endcase
  end

  assign ring_base = base_q;
  assign ring_cnt  = cnt_q;
  assign cpu_idx   = cpu_q;
  assign rx_en     = en_q;
  assign st_done   = stat_q[0];
  assign st_err    = stat_q[2];
  assign irq       = |(stat_word & mask_q);

  assign unused_wbits = ^reg_wdata;

endmodule

// File: rtl/rxdma_engine.sv
module rxdma_engine
  import rxdma_pkg::*;
#(
  parameter int IDX_W     = 8,
  parameter int BUF_BYTES = 2048
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_en,
  input  logic [31:0]      ring_base,
  input  logic [IDX_W:0]   ring_cnt,
  input  logic [IDX_W-1:0] cpu_idx,
  input  logic             idx_rst,
  input  logic             s_valid,
  input  logic [7:0]       s_data,
  input  logic             s_last,
  output logic             s_ready,
  output logic             mem_req,
  output logic             mem_we,
  output logic [31:0]      mem_addr,
  output logic [3:0]       mem_be,
  output logic [31:0]      mem_wdata,
  input  logic             mem_gnt,
  input  logic [31:0]      mem_rdata,
  output logic [IDX_W-1:0] dma_idx,
  output logic             busy,
  output logic             done_evt,
  output logic             err_evt,
  output eng_st_t          state
);

  localparam int CNT_W  = $clog2(BUF_BYTES + 1);
  localparam int WOFS_W = $clog2(BUF_BYTES/4 + 1);

  eng_st_t          st_q, st_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic [31:0]      ptr_q, ptr_d;
  logic [WOFS_W-1:0] wofs_q, wofs_d;
  logic [CNT_W-1:0] nb_q, nb_d;
  logic             last_q, last_d;
  logic             push, clr;
  logic [31:0]      pk_word;
  logic [3:0]       pk_be;
  logic [31:0]      desc_addr;
  logic             slot_free;
  logic             at_end;

  rxdma_pack u_pack (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (push),
    .lane  (nb_q[1:0]),
    .din   (s_data),
    .clr   (clr),
    .word  (pk_word),
    .be    (pk_be)
  );

  assign desc_addr = ring_base + {{(28-IDX_W){1'b0}}, idx_q, 4'h0};
  assign slot_free = (ring_cnt != '0) && (idx_q != cpu_idx);
  assign at_end    = ({1'b0, idx_q} == (ring_cnt - 1'b1));

  always_comb begin
    st_d      = st_q;
    idx_d     = idx_q;
    ptr_d     = ptr_q;
    wofs_d    = wofs_q;
    nb_d      = nb_q;
    last_d    = last_q;
    s_ready   = 1'b0;
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = desc_addr;
    mem_be    = 4'h0;
    mem_wdata = 32'h0;
    push      = 1'b0;
    clr       = 1'b0;
    done_evt  = 1'b0;
    err_evt   = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (rx_en && s_valid) st_d = slot_free ? ST_RPTR : ST_DROP;
      end
      ST_RPTR: begin
        mem_req  = 1'b1;
        mem_be   = 4'hF;
        mem_addr = desc_addr;
        if (mem_gnt) begin
          ptr_d  = mem_rdata;
          wofs_d = '0;
          nb_d   = '0;
          last_d = 1'b0;
          st_d   = ST_FILL;
        end
      end
      ST_FILL: begin
        s_ready = 1'b1;
        if (s_valid) begin
          if (nb_q < CNT_W'(BUF_BYTES)) begin
            push   = 1'b1;
            nb_d   = nb_q + 1'b1;
            last_d = s_last;
            if ((nb_q[1:0] == 2'b11) || s_last) st_d = ST_WDATA;
          end else if (s_last) begin
            st_d = ST_WDESC;
          end
        end
      end
      ST_WDATA: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = ptr_q + {{(30-WOFS_W){1'b0}}, wofs_q, 2'b00};
        mem_be    = pk_be;
        mem_wdata = pk_word;
        if (mem_gnt) begin
          wofs_d = wofs_q + 1'b1;
          clr    = 1'b1;
          st_d   = last_q ? ST_WDESC : ST_FILL;
        end
      end
      ST_WDESC: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = desc_addr + 32'd4;
        mem_be    = 4'hF;
        mem_wdata = {1'b1, 1'b1, LEN_W'(nb_q), 16'h0};
        if (mem_gnt) begin
          done_evt = 1'b1;
          idx_d    = at_end ? '0 : idx_q + 1'b1;
          st_d     = ST_IDLE;
        end
      end
      ST_DROP: begin
        s_ready = 1'b1;
        if (s_valid && s_last) begin
          err_evt = 1'b1;
          st_d    = ST_IDLE;
        end
      end
      default: st_d = ST_IDLE;
    endcase
    if (idx_rst) idx_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      idx_q  <= '0;
      ptr_q  <= 32'h0;
      wofs_q <= '0;
      nb_q   <= '0;
      last_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      idx_q <= idx_d;
      if (st_q == ST_RPTR) ptr_q <= ptr_d;
      if (st_q == ST_RPTR || st_q == ST_WDATA) wofs_q <= wofs_d;
      if (st_q == ST_RPTR || push) begin
        nb_q   <= nb_d;
        last_q <= last_d;
      end
    end
  end

  assign dma_idx = idx_q;
  assign busy    = (st_q != ST_IDLE);
  assign state   = st_q;

endmodule

// File: rtl/rxring_dma.sv
module rxring_dma
  import rxdma_pkg::*;
#(
  parameter int IDX_W     = 8,
  parameter int BUF_BYTES = 2048
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [2:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  input  logic        s_valid,
  input  logic [7:0]  s_data,
  input  logic        s_last,
  output logic        s_ready,
  output logic        mem_req,
  output logic        mem_we,
  output logic [31:0] mem_addr,
  output logic [3:0]  mem_be,
  output logic [31:0] mem_wdata,
  input  logic        mem_gnt,
  input  logic [31:0] mem_rdata,
  output logic        irq
);

  logic [31:0]      ring_base;
  logic [IDX_W:0]   ring_cnt;
  logic [IDX_W-1:0] cpu_idx;
  logic [IDX_W-1:0] dma_idx;
  logic             rx_en, idx_rst, busy, done_evt, err_evt;
  logic             st_done, st_err;
  eng_st_t          eng_state;

  rxdma_regs #(.IDX_W(IDX_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .dma_idx   (dma_idx),
    .busy      (busy),
    .done_evt  (done_evt),
    .err_evt   (err_evt),
    .ring_base (ring_base),
    .ring_cnt  (ring_cnt),
    .cpu_idx   (cpu_idx),
    .rx_en     (rx_en),
    .idx_rst   (idx_rst),
    .st_done   (st_done),
    .st_err    (st_err),
    .irq       (irq)
  );

  rxdma_engine #(.IDX_W(IDX_W), .BUF_BYTES(BUF_BYTES)) u_eng (
    .clk       (clk),
    .rst_n     (rst_n),
    .rx_en     (rx_en),
    .ring_base (ring_base),
    .ring_cnt  (ring_cnt),
    .cpu_idx   (cpu_idx),
    .idx_rst   (idx_rst),
    .s_valid   (s_valid),
    .s_data    (s_data),
    .s_last    (s_last),
    .s_ready   (s_ready),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_be    (mem_be),
    .mem_wdata (mem_wdata),
    .mem_gnt   (mem_gnt),
    .mem_rdata (mem_rdata),
    .dma_idx   (dma_idx),
    .busy      (busy),
    .done_evt  (done_evt),
    .err_evt   (err_evt),
    .state     (eng_state)
  );

endmodule

// File: rtl/rxring_dma_chk.sv
module rxring_dma_chk
  import rxdma_pkg::*;
#(
  parameter int IDX_W     = 8,
  parameter int BUF_BYTES = 2048
) (
  input logic             clk,
  input logic             rst_n,
  input logic             mem_req,
  input logic             mem_we,
  input logic             mem_gnt,
  input logic [31:0]      mem_addr,
  input logic [3:0]       mem_be,
  input logic [13:0]      desc_len,
  input logic             s_valid,
  input logic             s_ready,
  input logic             s_last,
  input logic             irst_wr,
  input logic             rx_en,
  input logic             st_done,
  input logic             st_err,
  input logic [IDX_W-1:0] dma_idx,
  input eng_st_t          state
);

  logic [15:0] acc_cnt;
  logic [15:0] exp_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc_cnt <= 16'h0;
    else if (state == ST_IDLE) acc_cnt <= 16'h0;
    else if (s_valid && s_ready) acc_cnt <= acc_cnt + 16'h1;
  end

  assign exp_len = (acc_cnt > 16'(BUF_BYTES)) ? 16'(BUF_BYTES) : acc_cnt;

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_gnt) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_be))); // R10

  AST_DONE_AFTER_DESC: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st_done) |-> $past(mem_req && mem_we && mem_gnt && (state == ST_WDESC))); // R3

  AST_LEN_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_WDESC && mem_req) |-> ({2'b00, desc_len} == exp_len)); // R6

  AST_ERR_ON_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st_err) |-> $past(s_valid && s_ready && s_last)); // R5

  AST_IDX_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    irst_wr |=> (dma_idx == '0)); // R8

  AST_IDLE_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (!rx_en && state == ST_IDLE) |-> !s_ready); // R9

endmodule

bind rxring_dma rxring_dma_chk #(.IDX_W(IDX_W), .BUF_BYTES(BUF_BYTES)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .mem_req  (mem_req),
  .mem_we   (mem_we),
  .mem_gnt  (mem_gnt),
  .mem_addr (mem_addr),
  .mem_be   (mem_be),
  .desc_len (mem_wdata[29:16]),
  .s_valid  (s_valid),
  .s_ready  (s_ready),
  .s_last   (s_last),
  .irst_wr  (idx_rst),
  .rx_en    (rx_en),
  .st_done  (st_done),
  .st_err   (st_err),
  .dma_idx  (dma_idx),
  .state    (eng_state)
);

// File: tb/sim_rxring_dma.sv
`timescale 1ns/1ps
module sim_rxring_dma;

  localparam int IDX_W = 4;
  localparam int BUF   = 32;
  localparam int NV    = 6;
  // {length[15:8], seed[7:0]}
  localparam logic [15:0] VEC [0:NV-1] = '{16'h0510, 16'h0820, 16'h0133, 16'h0D40, 16'h2855, 16'h2066};
  localparam logic [31:0] SENT = 32'hA5A5A5A5;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [2:0]  reg_addr = 3'd0;
  logic [31:0] reg_wdata = 32'h0;
  logic [31:0] reg_rdata;
  logic        s_valid = 1'b0;
  logic [7:0]  s_data = 8'h0;
  logic        s_last = 1'b0;
  logic        s_ready;
  logic        mem_req, mem_we, mem_gnt, irq;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic [3:0]  mem_be;

  logic [31:0] mem [0:1023];
  logic [1:0]  gcnt = 2'd0;
  int          wr_count = 0;
  logic [31:0] last_wr_addr = 32'h0;
  int          hold_viol = 0;
  logic        prev_stall = 1'b0;
  logic [31:0] prev_addr = 32'h0;
  int          checks = 0;
  int          errors = 0;
  logic        done_flag = 1'b0;

  always #2 clk = ~clk;

  rxring_dma #(.IDX_W(IDX_W), .BUF_BYTES(BUF)) u0 (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .s_valid(s_valid),
    .s_data(s_data), .s_last(s_last), .s_ready(s_ready), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_be(mem_be), .mem_wdata(mem_wdata),
    .mem_gnt(mem_gnt), .mem_rdata(mem_rdata), .irq(irq)
  );

  // memory model: one stalled cycle out of four
  assign mem_gnt   = mem_req && (gcnt != 2'd2);
  assign mem_rdata = mem[mem_addr[11:2]];

  always @(posedge clk) begin
    gcnt <= gcnt + 2'd1;
    if (mem_req && mem_gnt && mem_we) begin
      for (int b = 0; b < 4; b++)
        if (mem_be[b]) mem[mem_addr[11:2]][b*8 +: 8] <= mem_wdata[b*8 +: 8];
      wr_count     <= wr_count + 1;
      last_wr_addr <= mem_addr;
    end
  end

  always @(negedge clk) begin
    if (prev_stall && !(mem_req && mem_addr == prev_addr)) hold_viol = hold_viol + 1;
    prev_stall = mem_req && !mem_gnt;
    prev_addr  = mem_addr;
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic send_byte(input logic [7:0] d, input logic l);
    logic acc;
    @(negedge clk);
    s_valid = 1'b1; s_data = d; s_last = l;
    acc = 1'b0;
    while (!acc) begin
      #1;
      if (s_ready) begin
        @(posedge clk);
        acc = 1'b1;
      end else begin
        @(negedge clk);
      end
    end
    @(negedge clk);
    s_valid = 1'b0; s_last = 1'b0;
  endtask

  task automatic send_frame(input int len, input logic [7:0] seed);
    for (int i = 0; i < len; i++) send_byte(seed + 8'(i), i == len - 1);
  endtask

  task automatic wait_irq();
    int t;
    t = 0;
    while (!irq && t < 300) begin
      @(negedge clk);
      t++;
    end
  endtask

  task automatic prep_slot(input int slot);
    for (int w = 0; w < 16; w++) mem[256 + slot*16 + w] = SENT;
    mem[64 + slot*4 + 1] = 32'h4000_0000;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done_flag) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    int          slot, len, exp_len, bad, wc0;
    logic [7:0]  seed, got;

    for (int w = 0; w < 1024; w++) mem[w] = 32'h0;
    for (int s = 0; s < 4; s++) mem[64 + s*4] = 32'h400 + 32'(s) * 32'h40;

    repeat (5) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    #1;
    check("R1 irq", {31'h0, irq}, 32'h0);
    check("R1 s_ready/mem_req", {30'h0, s_ready, mem_req}, 32'h0);
    bad = 0;
    for (int a = 0; a < 8; a++) begin
      rd_reg(3'(a), rd);
      if (rd != 32'h0) bad++;
    end
    check("R1 registers zero", 32'(bad), 32'h0);

    wr_reg(3'd0, 32'h100);
    wr_reg(3'd1, 32'd4);
    wr_reg(3'd2, 32'd3);
    wr_reg(3'd7, 32'h0001_0000);
    wr_reg(3'd5, 32'h4);

    // vector table: lengths below, at and above the buffer size, wrapping the ring
    for (int k = 0; k < NV; k++) begin
      len     = int'(VEC[k][15:8]);
      seed    = VEC[k][7:0];
      slot    = k % 4;
      exp_len = (len > BUF) ? BUF : len;
      prep_slot(slot);
      send_frame(len, seed);
      wait_irq();
      repeat (2) @(negedge clk);
      bad = 0;
      for (int i = 0; i < 64; i++) begin
        got = mem[256 + slot*16 + i/4][(i%4)*8 +: 8];
        if (i < exp_len) begin
          if (got != seed + 8'(i)) bad++;
        end else if (got != 8'hA5) bad++;
      end
      check("R2 R10 R6 buffer bytes", 32'(bad), 32'h0);
      check(len > BUF ? "R6 truncated length" : "R3 info1 writeback",
            mem[64 + slot*4 + 1], 32'hC000_0000 | (32'(exp_len) << 16));
      check("R3 final write is info1", last_wr_addr, 32'h104 + 32'(slot) * 32'h10);
      rd_reg(3'd3, rd);
      check("R4 dma index", rd, 32'((k + 1) % 4));
      check("R7 irq on done", {31'h0, irq}, 32'h1);
      wr_reg(3'd6, 32'h0001_0000);
      #1 check("R7 irq cleared by W1C", {31'h0, irq}, 32'h0);
      mem[64 + slot*4 + 1] = 32'h4000_0000;
      wr_reg(3'd2, 32'(slot));
    end

    // R5: ring full (cpu index == dma index == 2)
    wr_reg(3'd2, 32'd2);
    prep_slot(2);
    wc0 = wr_count;
    send_frame(6, 8'h70);
    repeat (4) @(negedge clk);
    rd_reg(3'd6, rd);
    check("R5 error flag only", rd, 32'h8000_0000);
    check("R5 no memory writes", 32'(wr_count - wc0), 32'h0);
    check("R5 descriptor untouched", mem[64 + 9], 32'h4000_0000);
    rd_reg(3'd3, rd);
    check("R5 dma index held", rd, 32'd2);
    check("R7 masked error keeps irq low", {31'h0, irq}, 32'h0);
    wr_reg(3'd7, 32'h8001_0000);
    #1 check("R7 unmasked error raises irq", {31'h0, irq}, 32'h1);
    wr_reg(3'd6, 32'h8000_0000);
    #1 check("R7 error cleared", {31'h0, irq}, 32'h0);
    wr_reg(3'd2, 32'd1);

    // R9: disabled engine holds off the stream
    wr_reg(3'd5, 32'h0);
    wc0 = wr_count;
    @(negedge clk);
    s_valid = 1'b1; s_data = 8'h90; s_last = 1'b0;
    bad = 0;
    for (int c = 0; c < 8; c++) begin
      @(negedge clk);
      #1 if (s_ready) bad++;
    end
    s_valid = 1'b0;
    check("R9 s_ready low while disabled", 32'(bad), 32'h0);
    check("R9 no access while disabled", 32'(wr_count - wc0), 32'h0);
    wr_reg(3'd5, 32'h4);
    send_byte(8'h90, 1'b0);
    send_byte(8'h91, 1'b0);
    rd_reg(3'd5, rd);
    check("R9 busy mid-frame", rd, 32'hC);
    send_byte(8'h92, 1'b0);
    send_byte(8'h93, 1'b1);
    wait_irq();
    repeat (2) @(negedge clk);
    check("R3 info1 after gapped frame", mem[64 + 9], 32'hC004_0000);
    check("R2 gapped frame word", mem[256 + 32], 32'h9392_9190);
    rd_reg(3'd5, rd);
    check("R9 busy clear when idle", rd, 32'h4);

    // R7: writing zero leaves status
    wr_reg(3'd6, 32'h0);
    rd_reg(3'd6, rd);
    check("R7 zero write keeps status", rd, 32'h0001_0000);
    wr_reg(3'd6, 32'h0001_0000);

    // R8: index reset
    rd_reg(3'd3, rd);
    check("R4 index before reset", rd, 32'd3);
    wr_reg(3'd4, 32'h0001_0000);
    rd_reg(3'd3, rd);
    check("R8 index reset to zero", rd, 32'd0);

    check("R10 request held until grant", 32'(hold_viol), 32'h0);

    done_flag = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule